// File: doc/BRIEF.md
# Debug Bus Match Comparator Unit

This unit watches every access a CPU makes on its system bus and compares it against three programmed comparators, A, B and C. A comparator fires when the bus address equals its programmed address. Comparator A can also compare the bus data against a stored value, and a per-bit mask picks which data bits take part. Comparators A and B can also require a given access size. Every comparator can require a given access direction. The three match outputs feed a debug state sequencer, which lies outside this block. All configuration arrives on plain input ports.

A comparator can work in one of two modes. In forced mode it fires on the bus access itself. In tag mode it records matching opcode fetches in a small per-comparator pending queue, and it fires only when an instruction at that address reaches the execute stage. Tag mode ignores the direction, size and data qualifiers. A range mode uses the A/B pair as inclusive lower and upper bounds and reports an access either inside or outside the range on the A output. While the CPU is in background debug mode, no comparator fires and no tag is recorded.

Top module: `bus_match_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `match_o` is 3'b000. Reset empties every tag queue.
- R2: In forced mode (`cfg_tag[i]`=0, `cfg_en[i]`=1), an accepted access (`bus_valid`=1) whose address equals the comparator address sets `match_o[i]` in the next cycle. A different address leaves the bit at 0. Bit 0 is A, bit 1 is B and bit 2 is C.
- R3: Comparator A also needs `((bus_data ^ cfg_data_a) & cfg_mask_a) == 0`. A mask bit of 1 means that data bit is compared.
- R4: When `cfg_rwe[i]`=1, a match needs `bus_rnw == cfg_rw[i]`, where 1 means read. When `cfg_rwe[i]`=0, the direction is not checked.
- R5: When `cfg_sze[i]`=1 (A and B only), a match needs `bus_byte == cfg_sz[i]`, where 1 means byte and 0 means word. Comparator C has no size qualifier and matches both sizes.
- R6: While `dbg_mode`=1, `match_o` is 3'b000 in the next cycle, and any fetch seen in that cycle is not recorded as a tag.
- R7: In tag mode, an opcode fetch (`bus_fetch`=1) at the comparator address raises no match. `exec_valid` with `exec_addr` equal to that address then sets the bit in the next cycle, once for each recorded fetch. Direction, size and data qualifiers are ignored in this mode.
- R8: `flush` empties the tag queues. Each queue holds at most `TAG_DEPTH` (default 4) pending fetches, and further fetches are dropped.
- R9: With `range_en`=1 and `range_outside`=0, an access with `cfg_addr_a <= addr <= cfg_addr_b` sets `match_o[0]` using A's qualifiers. `match_o[1]` stays 0.
- R10: With `range_en`=1 and `range_outside`=1, `match_o[0]` is set for an access outside that inclusive range instead.
- R11: A comparator with `cfg_en[i]`=0 never sets its match bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_mode | input | 1 | Background debug mode; suppresses all matching |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | DATA_W | Bus data |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_byte | input | 1 | 1 = byte access, 0 = word |
| bus_fetch | input | 1 | Access is an opcode fetch |
| exec_valid | input | 1 | An instruction enters execution |
| exec_addr | input | ADDR_W | Address of the executing opcode |
| flush | input | 1 | Clears pending tags |
| cfg_en | input | 3 | Comparator enables |
| cfg_tag | input | 3 | Tag mode per comparator |
| cfg_rwe | input | 3 | Direction qualifier enable |
| cfg_rw | input | 3 | Required direction (1 = read) |
| cfg_sze | input | 2 | Size qualifier enable, A and B |
| cfg_sz | input | 2 | Required size (1 = byte), A and B |
| cfg_addr_a | input | ADDR_W | Comparator A address / lower bound |
| cfg_addr_b | input | ADDR_W | Comparator B address / upper bound |
| cfg_addr_c | input | ADDR_W | Comparator C address |
| cfg_data_a | input | DATA_W | Comparator A data value |
| cfg_mask_a | input | DATA_W | Comparator A data mask |
| range_en | input | 1 | A/B range mode |
| range_outside | input | 1 | Range fires outside instead of inside |
| match_o | output | 3 | Registered match per comparator |

## Verification
The hardest case to reach from the ports is a tag queue that is already full. It takes a run of fetches at the same address with no execute between them, followed by a run of executes. The bench issues six fetches, which raise no match, and then six executes. It expects exactly four pulses and then silence. A flush placed between a fetch and its execute, and a fetch issued during debug mode and executed after it ends, show that a pending tag can be dropped before it fires. The range bounds are checked at both inclusive edges and one address beyond each edge.

// File: rtl/dbgcmp_pkg.sv
package dbgcmp_pkg;

    localparam int NUM_CMP = 3;

    typedef enum int {
        CMP_A = 0,
        CMP_B = 1,
        CMP_C = 2
    } cmp_id_e;

    typedef struct packed {
        logic valid;
        logic rnw;
        logic is_byte;
        logic fetch;
    } bus_attr_t;

    typedef struct packed {
        logic en;
        logic tag;
        logic rwe;
        logic rw;
        logic sze;
        logic sz;
    } cmp_ctl_t;

    function automatic logic dir_ok(input cmp_ctl_t c, input bus_attr_t b);
        return !c.rwe || (c.rw == b.rnw);
    endfunction

    function automatic logic size_ok(input cmp_ctl_t c, input bus_attr_t b);
        return !c.sze || (c.sz == b.is_byte);
    endfunction

endpackage

// File: rtl/cmp_slice.sv
module cmp_slice
    import dbgcmp_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter bit HAS_SIZE = 1'b1,
    parameter bit HAS_DATA = 1'b0
) (
    input  bus_attr_t           attr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_data,
    input  cmp_ctl_t            ctl,
    input  logic [ADDR_W-1:0]   ref_addr,
    input  logic [DATA_W-1:0]   ref_data,
    input  logic [DATA_W-1:0]   ref_mask,
    output logic                addr_eq,
    output logic                qual_ok
);
    logic data_ok;
    logic sz_ok;

    assign addr_eq = (bus_addr == ref_addr);

    generate
        if (HAS_DATA) begin : g_data
            assign data_ok = (((bus_data ^ ref_data) & ref_mask) == '0);
        end else begin : g_nodata
            logic unused_data;
            assign unused_data = ^{bus_data, ref_data, ref_mask};
            assign data_ok = 1'b1;
        end

        if (HAS_SIZE) begin : g_size
            assign sz_ok = size_ok(ctl, attr);
        end else begin : g_nosize
            assign sz_ok = 1'b1;
        end
    endgenerate

    assign qual_ok = dir_ok(ctl, attr) && sz_ok && data_ok;
endmodule

// File: rtl/tag_queue.sv
module tag_queue #(
    parameter int ADDR_W    = 16,
    parameter int TAG_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              block,
    input  logic              flush,
    input  logic              fetch_hit,
    input  logic              exec_valid,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic [ADDR_W-1:0] ref_addr,
    output logic              hit
);
    localparam int CW = $clog2(TAG_DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(TAG_DEPTH);

    logic [CW-1:0] pending;
    logic          push;

    assign hit  = active && !block && exec_valid && (exec_addr == ref_addr) && (pending != '0);
    assign push = active && !block && fetch_hit && (pending != FULL);

    always_ff @(posedge clk) begin
        if (rst || flush || !active) begin
            pending <= '0;
        end else if (push && !hit) begin
            pending <= pending + 1'b1;
        end else if (hit && !push) begin
            pending <= pending - 1'b1;
        end
    end
endmodule

// File: rtl/bus_match_unit.sv
module bus_match_unit
    import dbgcmp_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int TAG_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_mode,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_rnw,
    input  logic              bus_byte,
    input  logic              bus_fetch,
    input  logic              exec_valid,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic              flush,
    input  logic [2:0]        cfg_en,
    input  logic [2:0]        cfg_tag,
    input  logic [2:0]        cfg_rwe,
    input  logic [2:0]        cfg_rw,
    input  logic [1:0]        cfg_sze,
    input  logic [1:0]        cfg_sz,
    input  logic [ADDR_W-1:0] cfg_addr_a,
    input  logic [ADDR_W-1:0] cfg_addr_b,
    input  logic [ADDR_W-1:0] cfg_addr_c,
    input  logic [DATA_W-1:0] cfg_data_a,
    input  logic [DATA_W-1:0] cfg_mask_a,
    input  logic              range_en,
    input  logic              range_outside,
    output logic [2:0]        match_o
);
    bus_attr_t         attr;
    cmp_ctl_t          ctl      [NUM_CMP];
    logic [ADDR_W-1:0] ref_addr [NUM_CMP];
    logic [NUM_CMP-1:0] addr_eq, qual_ok, tag_hit, forced_hit, raw_hit;
    logic [NUM_CMP-1:0] match_nxt;
    logic               in_range, range_hit, live;

    assign attr = '{valid: bus_valid, rnw: bus_rnw, is_byte: bus_byte, fetch: bus_fetch};
    assign live = bus_valid && !dbg_mode;

    assign ref_addr[CMP_A] = cfg_addr_a;
    assign ref_addr[CMP_B] = cfg_addr_b;
    assign ref_addr[CMP_C] = cfg_addr_c;

    genvar i;
    generate
        for (i = 0; i < NUM_CMP; i++) begin : g_cmp
            localparam bit SZ_Q = (i != CMP_C);
            localparam bit DT_Q = (i == CMP_A);

            if (SZ_Q) begin : g_szctl
                assign ctl[i] = '{en: cfg_en[i], tag: cfg_tag[i], rwe: cfg_rwe[i],
                                  rw: cfg_rw[i], sze: cfg_sze[i], sz: cfg_sz[i]};
            end else begin : g_noszctl
                assign ctl[i] = '{en: cfg_en[i], tag: cfg_tag[i], rwe: cfg_rwe[i],
                                  rw: cfg_rw[i], sze: 1'b0, sz: 1'b0};
            end

            cmp_slice #(
                .ADDR_W  (ADDR_W),
                .DATA_W  (DATA_W),
                .HAS_SIZE(SZ_Q),
                .HAS_DATA(DT_Q)
            ) u_slice (
                .attr    (attr),
                .bus_addr(bus_addr),
                .bus_data(bus_data),
                .ctl     (ctl[i]),
                .ref_addr(ref_addr[i]),
                .ref_data(cfg_data_a),
                .ref_mask(cfg_mask_a),
                .addr_eq (addr_eq[i]),
                .qual_ok (qual_ok[i])
            );

            tag_queue #(
                .ADDR_W   (ADDR_W),
                .TAG_DEPTH(TAG_DEPTH)
            ) u_tagq (
                .clk       (clk),
                .rst       (rst),
                .active    (ctl[i].en && ctl[i].tag && !(range_en && i != CMP_C)),
                .block     (dbg_mode),
                .flush     (flush),
                .fetch_hit (bus_valid && bus_fetch && addr_eq[i]),
                .exec_valid(exec_valid),
                .exec_addr (exec_addr),
                .ref_addr  (ref_addr[i]),
                .hit       (tag_hit[i])
            );

            assign forced_hit[i] = live && ctl[i].en && !ctl[i].tag && addr_eq[i] && qual_ok[i];
            assign raw_hit[i]    = forced_hit[i] || tag_hit[i];
        end
    endgenerate

    assign in_range  = (bus_addr >= cfg_addr_a) && (bus_addr <= cfg_addr_b);
    assign range_hit = live && cfg_en[CMP_A] && qual_ok[CMP_A] && (in_range ^ range_outside);

    always_comb begin
        match_nxt = raw_hit;
        if (range_en) begin
            match_nxt[CMP_A] = range_hit;
            match_nxt[CMP_B] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_o <= '0;
        end else begin
            match_o <= match_nxt;
        end
    end
endmodule

// File: rtl/bus_match_chk.sv
module bus_match_chk (
    input logic       clk,
    input logic       rst,
    input logic       dbg_mode,
    input logic       bus_valid,
    input logic       exec_valid,
    input logic [2:0] cfg_en,
    input logic       range_en,
    input logic [2:0] match_o
);
    // R1: reset leaves the outputs low in the following cycle
    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (match_o == 3'b000));

    // R6: debug mode suppresses every comparator
    p_dbg_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        dbg_mode |=> (match_o == 3'b000));

    // R2: no bus access and no execution means no match
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (!bus_valid && !exec_valid) |=> (match_o == 3'b000));

    // R9: range mode keeps the B output low
    p_range_b_low_r9: assert property (@(posedge clk) disable iff (rst)
        range_en |=> !match_o[1]);

    // R11: a disabled comparator stays silent
    p_disabled_c_r11: assert property (@(posedge clk) disable iff (rst)
        !cfg_en[2] |=> !match_o[2]);

    p_disabled_b_r11: assert property (@(posedge clk) disable iff (rst)
        !cfg_en[1] |=> !match_o[1]);
endmodule

bind bus_match_unit bus_match_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .dbg_mode  (dbg_mode),
    .bus_valid (bus_valid),
    .exec_valid(exec_valid),
    .cfg_en    (cfg_en),
    .range_en  (range_en),
    .match_o   (match_o)
);

// File: tb/sim_bus_match_unit.sv
`timescale 1ns/1ps
module sim_bus_match_unit;
    localparam int AW = 16;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst;
    logic dbg_mode, bus_valid, bus_rnw, bus_byte, bus_fetch, exec_valid, flush;
    logic [AW-1:0] bus_addr, exec_addr, cfg_addr_a, cfg_addr_b, cfg_addr_c;
    logic [DW-1:0] bus_data, cfg_data_a, cfg_mask_a;
    logic [2:0] cfg_en, cfg_tag, cfg_rwe, cfg_rw, match_o;
    logic [1:0] cfg_sze, cfg_sz;
    logic range_en, range_outside;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bus_match_unit #(.ADDR_W(AW), .DATA_W(DW), .TAG_DEPTH(4)) u0 (.*);

    task automatic check(input logic [2:0] exp, input string req);
        checks++;
        if (match_o !== exp) begin
            errors++;
            $display("FAIL %s: match_o=%b expected=%b", req, match_o, exp);
        end
    endtask

    task automatic idle_inputs();
        bus_valid = 0; bus_addr = '0; bus_data = '0; bus_rnw = 1; bus_byte = 0;
        bus_fetch = 0; exec_valid = 0; exec_addr = '0; flush = 0; dbg_mode = 0;
    endtask

    task automatic clear_cfg();
        cfg_en = '0; cfg_tag = '0; cfg_rwe = '0; cfg_rw = '0; cfg_sze = '0; cfg_sz = '0;
        cfg_addr_a = '0; cfg_addr_b = '0; cfg_addr_c = '0;
        cfg_data_a = '0; cfg_mask_a = '0; range_en = 0; range_outside = 0;
    endtask

    // One bus access; the registered result is checked one clock later.
    task automatic access(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic rnw,
                          input logic byt, input logic fet, input logic [2:0] exp, input string req);
        @(negedge clk);
        bus_valid = 1; bus_addr = a; bus_data = d; bus_rnw = rnw; bus_byte = byt; bus_fetch = fet;
        @(negedge clk);
        check(exp, req);
        bus_valid = 0; bus_fetch = 0;
    endtask

    task automatic execute(input logic [AW-1:0] a, input logic [2:0] exp, input string req);
        @(negedge clk);
        exec_valid = 1; exec_addr = a;
        @(negedge clk);
        check(exp, req);
        exec_valid = 0;
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush = 1;
        @(negedge clk);
        flush = 0;
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        check(3'b000, "R1 in reset");
        rst = 0;
        @(negedge clk);
        check(3'b000, "R1 after reset");
    endtask

    task automatic t_forced();
        clear_cfg();
        cfg_en = 3'b101; cfg_addr_a = 16'h1234; cfg_addr_c = 16'h4000;
        access(16'h1234, 16'h0, 1, 0, 0, 3'b001, "R2 A hit");
        access(16'h1235, 16'h0, 1, 0, 0, 3'b000, "R2 A miss");
        access(16'h4000, 16'h0, 0, 1, 0, 3'b100, "R2 C hit");
        cfg_en = 3'b001;
        access(16'h4000, 16'h0, 0, 1, 0, 3'b000, "R11 C disabled");
        cfg_en = 3'b000;
        access(16'h1234, 16'h0, 1, 0, 0, 3'b000, "R11 A disabled");
    endtask

    task automatic t_data();
        clear_cfg();
        cfg_en = 3'b001; cfg_addr_a = 16'h0200; cfg_data_a = 16'h12AB; cfg_mask_a = 16'h00FF;
        access(16'h0200, 16'h99AB, 1, 0, 0, 3'b001, "R3 masked high byte");
        access(16'h0200, 16'h12AC, 1, 0, 0, 3'b000, "R3 low byte differs");
        cfg_mask_a = 16'hFFFF;
        access(16'h0200, 16'h99AB, 1, 0, 0, 3'b000, "R3 full mask mismatch");
        access(16'h0200, 16'h12AB, 1, 0, 0, 3'b001, "R3 full mask equal");
    endtask

    task automatic t_dir();
        clear_cfg();
        cfg_en = 3'b010; cfg_addr_b = 16'h0300; cfg_rwe = 3'b010; cfg_rw = 3'b000;
        access(16'h0300, 16'h0, 1, 0, 0, 3'b000, "R4 read rejected");
        access(16'h0300, 16'h0, 0, 0, 0, 3'b010, "R4 write accepted");
        cfg_rwe = 3'b000;
        access(16'h0300, 16'h0, 1, 0, 0, 3'b010, "R4 direction off");
    endtask

    task automatic t_size();
        clear_cfg();
        cfg_en = 3'b110; cfg_addr_b = 16'h0400; cfg_addr_c = 16'h0500;
        cfg_sze = 2'b10; cfg_sz = 2'b10;
        access(16'h0400, 16'h0, 1, 0, 0, 3'b000, "R5 B word rejected");
        access(16'h0400, 16'h0, 1, 1, 0, 3'b010, "R5 B byte accepted");
        access(16'h0500, 16'h0, 1, 0, 0, 3'b100, "R5 C word");
        access(16'h0500, 16'h0, 1, 1, 0, 3'b100, "R5 C byte");
    endtask

    task automatic t_dbg();
        clear_cfg();
        cfg_en = 3'b101; cfg_addr_a = 16'h0600; cfg_tag = 3'b100; cfg_addr_c = 16'h2000;
        dbg_mode = 1;
        access(16'h0600, 16'h0, 1, 0, 0, 3'b000, "R6 forced suppressed");
        access(16'h2000, 16'h0, 1, 0, 1, 3'b000, "R6 fetch in debug");
        dbg_mode = 0;
        execute(16'h2000, 3'b000, "R6 tag not recorded");
    endtask

    task automatic t_tag();
        clear_cfg();
        cfg_en = 3'b100; cfg_tag = 3'b100; cfg_addr_c = 16'h2000;
        cfg_rwe = 3'b100; cfg_rw = 3'b000;
        access(16'h2000, 16'h0, 1, 0, 1, 3'b000, "R7 no match at fetch");
        execute(16'h2010, 3'b000, "R7 other exec addr");
        execute(16'h2000, 3'b100, "R7 match at execute");
        execute(16'h2000, 3'b000, "R7 tag consumed");
    endtask

    task automatic t_flush_depth();
        clear_cfg();
        cfg_en = 3'b100; cfg_tag = 3'b100; cfg_addr_c = 16'h3000;
        access(16'h3000, 16'h0, 1, 0, 1, 3'b000, "R8 fetch");
        pulse_flush();
        execute(16'h3000, 3'b000, "R8 flushed");
        for (int k = 0; k < 6; k++) access(16'h3000, 16'h0, 1, 0, 1, 3'b000, "R8 fill");
        for (int k = 0; k < 6; k++)
            execute(16'h3000, (k < 4) ? 3'b100 : 3'b000, "R8 depth limit");
    endtask

    task automatic t_range();
        clear_cfg();
        cfg_en = 3'b011; cfg_addr_a = 16'h1000; cfg_addr_b = 16'h10FF; range_en = 1;
        access(16'h1000, 16'h0, 1, 0, 0, 3'b001, "R9 lower edge");
        access(16'h10FF, 16'h0, 1, 0, 0, 3'b001, "R9 upper edge, B low");
        access(16'h1100, 16'h0, 1, 0, 0, 3'b000, "R9 above");
        access(16'h0FFF, 16'h0, 1, 0, 0, 3'b000, "R9 below");
        range_outside = 1;
        access(16'h0FFF, 16'h0, 1, 0, 0, 3'b001, "R10 below");
        access(16'h1100, 16'h0, 1, 0, 0, 3'b001, "R10 above");
        access(16'h1050, 16'h0, 1, 0, 0, 3'b000, "R10 inside");
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        clear_cfg();
        t_reset();
        t_forced();
        t_data();
        t_dir();
        t_size();
        t_dbg();
        t_tag();
        t_flush_depth();
        t_range();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule